// File: doc/BRIEF.md
# Serial Command Byte Parser

This block sits between a host byte stream and a synchronous serial engine. Opcodes and their operand bytes arrive on a valid/ready command stream. Replies leave on a second valid/ready stream through a response FIFO. The parser handles the pin, loopback, divisor, clock-mode, flush, wait and error opcodes itself. Any byte with bit 7 low is a data-shifting opcode. The parser hands that opcode to a separate shift engine and forwards the following command bytes to it unchanged until the engine reports completion. Bytes returned by the engine are queued in the same response FIFO.

The parser holds the block's control state: a 16-bit pin value register, a 16-bit pin direction register, a loopback flag, a 16-bit clock divisor and three clock-mode flags. These go to the pads and to the clock generator. Deasserting `enable` holds the entire block in its reset state, including the FIFO contents and any pending stall.

States: `ST_IDLE` (waits for an opcode), `ST_VAL` / `ST_DIR` (pin value byte, then direction byte), `ST_DIVL` / `ST_DIVH` (divisor low byte, then high byte), `ST_READ` (push one pin byte), `ST_ERR_TAG` / `ST_ERR_OP` (two-byte error reply), `ST_WAIT` (stall on the wait pin), `ST_SH_GO` (start strobe to the shift engine), `ST_SH_RUN` (pass-through until the engine finishes). Transitions are as follows. `ST_IDLE` dispatches on the accepted opcode. Each operand state advances when its byte is accepted. `ST_READ`, `ST_ERR_TAG` and `ST_ERR_OP` advance when the FIFO has room. `ST_WAIT` returns to idle when the wait pin reaches the requested level. `ST_SH_GO` always moves to `ST_SH_RUN`. `ST_SH_RUN` returns to idle when `sh_done` is seen.

Top module: `serial_cmd_parser`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0, `pin_out`, `pin_dir`, `div_val` and `loop_en` are 0, `three_ph_en` and `adapt_en` are 0, and `div5_en` is 1.
- R2: Opcode 0x80 followed by a value byte and then a direction byte loads `pin_out[7:0]` and `pin_dir[7:0]`. Opcode 0x82 does the same for bits 15:8. The registers change at the edge that accepts the direction byte and at no other time.
- R3: Opcode 0x81 queues one reply byte equal to `pin_in[7:0]`. Opcode 0x83 queues `pin_in[15:8]`.
- R4: Opcode 0x84 sets `loop_en`; opcode 0x85 clears it.
- R5: Opcode 0x86 followed by a low byte and then a high byte loads `div_val` = {high, low}. `div_val` changes only at the edge that accepts a command byte.
- R6: 0x8A clears `div5_en` and 0x8B sets it. 0x8C sets `three_ph_en` and 0x8D clears it. 0x96 sets `adapt_en` and 0x97 clears it.
- R7: Accepting opcode 0x87 raises `rsp_flush` for exactly the following cycle. `rsp_flush` is never high otherwise.
- R8: Opcode 0x88 holds `cmd_ready` low until `pin_in[5]` is 1. Opcode 0x89 holds it low until `pin_in[5]` is 0.
- R9: Any other opcode with bit 7 set queues two reply bytes: 0xFA, then the opcode itself.
- R10: An opcode with bit 7 low produces a one-cycle `sh_start` with `sh_op` equal to the opcode; `cmd_ready` is 0 in that cycle. The following command bytes are forwarded on `sh_in_*`, with `cmd_ready` following `sh_in_ready`, until `sh_done`. Bytes offered on `sh_rsp_*` meanwhile enter the reply FIFO.
- R11: Replies leave in the order they were queued. The FIFO holds 16 bytes. While it is full, a pending reply stalls the parser with `cmd_ready` low, and a held reply byte stays stable until `rsp_ready` takes it.
- R12: While `enable` is 0, the block returns to its R1 state with `cmd_ready` at 0 and all queued replies discarded. This also ends an R8 stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low holds the block in reset |
| cmd_valid | input | 1 | Command byte valid |
| cmd_data | input | 8 | Command byte |
| cmd_ready | output | 1 | Command byte accepted when high with valid |
| rsp_valid | output | 1 | Reply byte available |
| rsp_data | output | 8 | Reply byte (FIFO head) |
| rsp_ready | input | 1 | Host takes the reply byte |
| rsp_flush | output | 1 | One-cycle request to send buffered replies now |
| sh_start | output | 1 | One-cycle start strobe to the shift engine |
| sh_op | output | 8 | Shift opcode, valid with `sh_start` and during the operation |
| sh_in_valid | output | 1 | Forwarded command byte valid |
| sh_in_data | output | 8 | Forwarded command byte |
| sh_in_ready | input | 1 | Shift engine accepts a forwarded byte |
| sh_done | input | 1 | Shift engine finished the operation |
| sh_rsp_valid | input | 1 | Shift engine reply byte valid |
| sh_rsp_data | input | 8 | Shift engine reply byte |
| sh_rsp_ready | output | 1 | Reply byte from the shift engine accepted |
| pin_in | input | 16 | Sampled pin levels |
| pin_out | output | 16 | Pin value register |
| pin_dir | output | 16 | Pin direction register (1 = output) |
| loop_en | output | 1 | Serial loopback enable |
| div_val | output | 16 | Clock divisor |
| div5_en | output | 1 | Divide-by-5 prescaler enable |
| three_ph_en | output | 1 | Three-phase clocking enable |
| adapt_en | output | 1 | Adaptive clocking enable |

## Verification
The bench fills the reply FIFO with alternating low and high pin reads until a seventeenth read must stall. A design with an off-by-one full flag would either lose that byte or reorder replies. The bench also holds the shift engine's ready low while a payload byte waits. A parser that swallowed that byte or let `cmd_ready` run ahead would show a wrong forwarded count or value. Both wait polarities are exercised, and `enable` is dropped in the middle of a stall. A parser that waited on the wrong level, or kept the stall or the stale registers through a disable, would keep `cmd_ready` low or return non-reset outputs. Unknown opcodes such as 0x9C and 0x8E must come back as 0xFA followed by the opcode, never as the reverse order or as a single byte.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int PIN_W   = 16;
    localparam int LANE_W  = 8;
    localparam int N_LANE  = PIN_W / LANE_W;

    localparam logic [7:0] OP_SET_LO   = 8'h80;
    localparam logic [7:0] OP_GET_LO   = 8'h81;
    localparam logic [7:0] OP_SET_HI   = 8'h82;
    localparam logic [7:0] OP_GET_HI   = 8'h83;
    localparam logic [7:0] OP_LOOP_ON  = 8'h84;
    localparam logic [7:0] OP_LOOP_OFF = 8'h85;
    localparam logic [7:0] OP_DIVISOR  = 8'h86;
    localparam logic [7:0] OP_FLUSH    = 8'h87;
    localparam logic [7:0] OP_WAIT_HI  = 8'h88;
    localparam logic [7:0] OP_WAIT_LO  = 8'h89;
    localparam logic [7:0] OP_PRE_OFF  = 8'h8A;
    localparam logic [7:0] OP_PRE_ON   = 8'h8B;
    localparam logic [7:0] OP_3PH_ON   = 8'h8C;
    localparam logic [7:0] OP_3PH_OFF  = 8'h8D;
    localparam logic [7:0] OP_ADP_ON   = 8'h96;
    localparam logic [7:0] OP_ADP_OFF  = 8'h97;
    localparam logic [7:0] ERR_TAG     = 8'hFA;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VAL,
        ST_DIR,
        ST_DIVL,
        ST_DIVH,
        ST_READ,
        ST_ERR_TAG,
        ST_ERR_OP,
        ST_WAIT,
        ST_SH_GO,
        ST_SH_RUN
    } pstate_t;

    // Next state chosen by an opcode accepted in idle.
    function automatic pstate_t dispatch(input logic [7:0] op);
        pstate_t nx;
        if (!op[7]) begin
            nx = ST_SH_GO;
        end else begin
            unique case (op)
                OP_SET_LO, OP_SET_HI:               nx = ST_VAL;
                OP_GET_LO, OP_GET_HI:               nx = ST_READ;
                OP_DIVISOR:                         nx = ST_DIVL;
                OP_WAIT_HI, OP_WAIT_LO:             nx = ST_WAIT;
                OP_LOOP_ON, OP_LOOP_OFF, OP_FLUSH,
                OP_PRE_OFF, OP_PRE_ON, OP_3PH_ON,
                OP_3PH_OFF, OP_ADP_ON, OP_ADP_OFF:  nx = ST_IDLE;
                default:                            nx = ST_ERR_TAG;
            endcase
        end
        return nx;
    endfunction

endpackage

// File: rtl/scp_rsp_fifo.sv
module scp_rsp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   CAP  = (AW + 1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [AW:0]   cnt;
    logic          do_wr;
    logic          do_rd;

    assign full    = (cnt == CAP);
    assign empty   = (cnt == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clear) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) begin
                wp <= (wp == LAST) ? '0 : wp + AW'(1);
            end
            if (do_rd) begin
                rp <= (rp == LAST) ? '0 : rp + AW'(1);
            end
            unique case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + (AW + 1)'(1);
                2'b01:   cnt <= cnt - (AW + 1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/scp_cmd_fsm.sv
module scp_cmd_fsm
    import scp_pkg::*;
#(
    parameter int WAIT_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_data,
    output logic             cmd_ready,
    input  logic             fifo_full,
    output logic             push,
    output logic [7:0]       push_data,
    output logic             shift_active,
    output logic             sh_start,
    output logic [7:0]       sh_op,
    output logic             sh_in_valid,
    output logic [7:0]       sh_in_data,
    input  logic             sh_in_ready,
    input  logic             sh_done,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_dir,
    output logic             loop_en,
    output logic [15:0]      div_val,
    output logic             div5_en,
    output logic             three_ph_en,
    output logic             adapt_en,
    output logic             flush
);
    pstate_t    state;
    pstate_t    state_nx;
    logic [7:0] opc;
    logic [7:0] hold;
    logic       accept;
    logic       wait_met;
    logic [7:0] pin_byte;

    assign accept   = cmd_valid && cmd_ready;
    assign wait_met = (pin_in[WAIT_BIT] == (opc == OP_WAIT_HI));
    assign pin_byte = opc[1] ? pin_in[15:8] : pin_in[7:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (!enable) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = dispatch(cmd_data);
            ST_VAL:     if (accept) state_nx = ST_DIR;
            ST_DIR:     if (accept) state_nx = ST_IDLE;
            ST_DIVL:    if (accept) state_nx = ST_DIVH;
            ST_DIVH:    if (accept) state_nx = ST_IDLE;
            ST_READ:    if (!fifo_full) state_nx = ST_IDLE;
            ST_ERR_TAG: if (!fifo_full) state_nx = ST_ERR_OP;
            ST_ERR_OP:  if (!fifo_full) state_nx = ST_IDLE;
            ST_WAIT:    if (wait_met) state_nx = ST_IDLE;
            ST_SH_GO:   state_nx = ST_SH_RUN;
            ST_SH_RUN:  if (sh_done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        cmd_ready    = 1'b0;
        push         = 1'b0;
        push_data    = 8'h00;
        shift_active = 1'b0;
        sh_start     = 1'b0;
        sh_in_valid  = 1'b0;
        unique case (state)
            ST_IDLE, ST_VAL, ST_DIR, ST_DIVL, ST_DIVH: begin
                cmd_ready = enable;
            end
            ST_READ: begin
                push      = !fifo_full;
                push_data = pin_byte;
            end
            ST_ERR_TAG: begin
                push      = !fifo_full;
                push_data = ERR_TAG;
            end
            ST_ERR_OP: begin
                push      = !fifo_full;
                push_data = opc;
            end
            ST_WAIT: begin
                cmd_ready = 1'b0;
            end
            ST_SH_GO: begin
                sh_start = 1'b1;
            end
            ST_SH_RUN: begin
                shift_active = 1'b1;
                cmd_ready    = enable && sh_in_ready;
                sh_in_valid  = cmd_valid;
            end
            default: begin
                cmd_ready = 1'b0;
            end
        endcase
    end

    assign sh_op      = opc;
    assign sh_in_data = cmd_data;

    // Opcode, operand holding and single-byte controls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc         <= 8'h00;
            hold        <= 8'h00;
            loop_en     <= 1'b0;
            div_val     <= 16'h0000;
            div5_en     <= 1'b1;
            three_ph_en <= 1'b0;
            adapt_en    <= 1'b0;
            flush       <= 1'b0;
        end else if (!enable) begin
            opc         <= 8'h00;
            hold        <= 8'h00;
            loop_en     <= 1'b0;
            div_val     <= 16'h0000;
            div5_en     <= 1'b1;
            three_ph_en <= 1'b0;
            adapt_en    <= 1'b0;
            flush       <= 1'b0;
        end else begin
            flush <= 1'b0;
            if (accept) begin
                unique case (state)
                    ST_IDLE: begin
                        opc <= cmd_data;
                        unique case (cmd_data)
                            OP_LOOP_ON:  loop_en     <= 1'b1;
                            OP_LOOP_OFF: loop_en     <= 1'b0;
                            OP_FLUSH:    flush       <= 1'b1;
                            OP_PRE_OFF:  div5_en     <= 1'b0;
                            OP_PRE_ON:   div5_en     <= 1'b1;
                            OP_3PH_ON:   three_ph_en <= 1'b1;
                            OP_3PH_OFF:  three_ph_en <= 1'b0;
                            OP_ADP_ON:   adapt_en    <= 1'b1;
                            OP_ADP_OFF:  adapt_en    <= 1'b0;
                            default:     ;
                        endcase
                    end
                    ST_VAL, ST_DIVL: hold <= cmd_data;
                    ST_DIVH:         div_val <= {cmd_data, hold};
                    default:         ;
                endcase
            end
        end
    end

    // Pin byte lanes, selected by opcode bit 1
    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        logic [LANE_W-1:0] val_q;
        logic [LANE_W-1:0] dir_q;
        logic              hit;

        assign hit = accept && (state == ST_DIR) && (int'(opc[1]) == g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
                dir_q <= '0;
            end else if (!enable) begin
                val_q <= '0;
                dir_q <= '0;
            end else if (hit) begin
                val_q <= hold;
                dir_q <= cmd_data;
            end
        end

        assign pin_out[g*LANE_W +: LANE_W] = val_q;
        assign pin_dir[g*LANE_W +: LANE_W] = dir_q;
    end

endmodule

// File: rtl/serial_cmd_parser.sv
module serial_cmd_parser
    import scp_pkg::*;
#(
    parameter int RSP_DEPTH = 16,
    parameter int WAIT_BIT  = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_data,
    output logic        cmd_ready,
    output logic        rsp_valid,
    output logic [7:0]  rsp_data,
    input  logic        rsp_ready,
    output logic        rsp_flush,
    output logic        sh_start,
    output logic [7:0]  sh_op,
    output logic        sh_in_valid,
    output logic [7:0]  sh_in_data,
    input  logic        sh_in_ready,
    input  logic        sh_done,
    input  logic        sh_rsp_valid,
    input  logic [7:0]  sh_rsp_data,
    output logic        sh_rsp_ready,
    input  logic [15:0] pin_in,
    output logic [15:0] pin_out,
    output logic [15:0] pin_dir,
    output logic        loop_en,
    output logic [15:0] div_val,
    output logic        div5_en,
    output logic        three_ph_en,
    output logic        adapt_en
);
    logic       fifo_full;
    logic       fifo_empty;
    logic       fsm_push;
    logic [7:0] fsm_push_data;
    logic       shift_active;
    logic       wr_en;
    logic [7:0] wr_data;

    scp_cmd_fsm #(.WAIT_BIT(WAIT_BIT)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .cmd_valid    (cmd_valid),
        .cmd_data     (cmd_data),
        .cmd_ready    (cmd_ready),
        .fifo_full    (fifo_full),
        .push         (fsm_push),
        .push_data    (fsm_push_data),
        .shift_active (shift_active),
        .sh_start     (sh_start),
        .sh_op        (sh_op),
        .sh_in_valid  (sh_in_valid),
        .sh_in_data   (sh_in_data),
        .sh_in_ready  (sh_in_ready),
        .sh_done      (sh_done),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_dir      (pin_dir),
        .loop_en      (loop_en),
        .div_val      (div_val),
        .div5_en      (div5_en),
        .three_ph_en  (three_ph_en),
        .adapt_en     (adapt_en),
        .flush        (rsp_flush)
    );

    // The parser never pushes while a shift runs, so the two writers never collide.
    assign sh_rsp_ready = enable && shift_active && !fifo_full;
    assign wr_en        = fsm_push || (sh_rsp_valid && sh_rsp_ready);
    assign wr_data      = shift_active ? sh_rsp_data : fsm_push_data;
    assign rsp_valid    = !fifo_empty;

    scp_rsp_fifo #(.W(8), .DEPTH(RSP_DEPTH)) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!enable),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rsp_ready),
        .rd_data (rsp_data),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

endmodule

// File: rtl/scp_checker.sv
module scp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic        cmd_valid,
    input logic [7:0]  cmd_data,
    input logic        cmd_ready,
    input logic        rsp_valid,
    input logic [7:0]  rsp_data,
    input logic        rsp_ready,
    input logic        rsp_flush,
    input logic        sh_start,
    input logic [15:0] pin_out,
    input logic [15:0] pin_dir,
    input logic        loop_en,
    input logic [15:0] div_val,
    input logic        div5_en
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    p_pin_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !acc) |=> ($stable(pin_out) && $stable(pin_dir)));

    p_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !acc) |=> $stable(div_val));

    p_flush_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_flush |-> $past(enable && acc && cmd_data == 8'h87));

    p_start_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !cmd_ready);

    p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    p_disable_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!rsp_valid && pin_dir == 16'h0 && !loop_en && div5_en));

endmodule

bind serial_cmd_parser scp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_ready (rsp_ready),
    .rsp_flush (rsp_flush),
    .sh_start  (sh_start),
    .pin_out   (pin_out),
    .pin_dir   (pin_dir),
    .loop_en   (loop_en),
    .div_val   (div_val),
    .div5_en   (div5_en)
);

// File: tb/tb_serial_cmd_parser.sv
`timescale 1ns/1ps
module tb_serial_cmd_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_data = 8'h00;
    logic        cmd_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        rsp_ready = 1'b0;
    logic        rsp_flush;
    logic        sh_start;
    logic [7:0]  sh_op;
    logic        sh_in_valid;
    logic [7:0]  sh_in_data;
    logic        sh_in_ready = 1'b0;
    logic        sh_done = 1'b0;
    logic        sh_rsp_valid = 1'b0;
    logic [7:0]  sh_rsp_data = 8'h00;
    logic        sh_rsp_ready;
    logic [15:0] pin_in = 16'h0000;
    logic [15:0] pin_out;
    logic [15:0] pin_dir;
    logic        loop_en;
    logic [15:0] div_val;
    logic        div5_en;
    logic        three_ph_en;
    logic        adapt_en;

    int n_chk = 0;
    int n_err = 0;
    int n_start = 0;
    logic [7:0] last_op = 8'h00;
    int n_fwd = 0;
    logic [7:0] fwd [8];

    always #4 clk = ~clk;

    serial_cmd_parser dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
        .rsp_flush(rsp_flush),
        .sh_start(sh_start), .sh_op(sh_op),
        .sh_in_valid(sh_in_valid), .sh_in_data(sh_in_data), .sh_in_ready(sh_in_ready),
        .sh_done(sh_done),
        .sh_rsp_valid(sh_rsp_valid), .sh_rsp_data(sh_rsp_data), .sh_rsp_ready(sh_rsp_ready),
        .pin_in(pin_in), .pin_out(pin_out), .pin_dir(pin_dir), .loop_en(loop_en),
        .div_val(div_val), .div5_en(div5_en), .three_ph_en(three_ph_en), .adapt_en(adapt_en)
    );

    // Shift-engine side monitor, sampled mid-cycle
    always @(negedge clk) begin
        #2;
        if (sh_start) begin
            n_start++;
            last_op = sh_op;
        end
        if (sh_in_valid && sh_in_ready) begin
            if (n_fwd < 8) fwd[n_fwd] = sh_in_data;
            n_fwd++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Offer one command byte, return at the negedge after it is taken.
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = b;
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
    endtask

    task automatic pop(input string req, input logic [7:0] exp);
        int n = 0;
        while (!rsp_valid && n < 50) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk(req, {23'd0, rsp_valid, rsp_data}, {23'd0, 1'b1, exp});
        rsp_ready = 1'b1;
        @(posedge clk);
        #1;
        rsp_ready = 1'b0;
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 cmd_ready", 32'(cmd_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 pin_out/dir", {pin_out, pin_dir}, 32'h0);
        chk("R1 div_val", 32'(div_val), 32'h0);
        chk("R1 flags", {28'd0, loop_en, div5_en, three_ph_en, adapt_en}, 32'b0100);
    endtask

    task automatic t_pins();
        send(8'h80); send(8'h5A);
        chk("R2 no change before dir byte", {pin_out, pin_dir}, 32'h0);
        send(8'h0F);
        chk("R2 low lane", {pin_out, pin_dir}, 32'h005A_000F);
        send(8'h82); send(8'hC3); send(8'hF0);
        chk("R2 high lane", {pin_out, pin_dir}, 32'hC35A_F00F);
    endtask

    task automatic t_read();
        pin_in = 16'hB44B;
        send(8'h81);
        pop("R3 low byte", 8'h4B);
        send(8'h83);
        pop("R3 high byte", 8'hB4);
    endtask

    task automatic t_loop();
        send(8'h84);
        chk("R4 loop on", 32'(loop_en), 32'd1);
        send(8'h85);
        chk("R4 loop off", 32'(loop_en), 32'd0);
    endtask

    task automatic t_div();
        send(8'h86); send(8'h34);
        chk("R5 div before high byte", 32'(div_val), 32'h0);
        send(8'h12);
        chk("R5 div value", 32'(div_val), 32'h1234);
    endtask

    task automatic t_modes();
        send(8'h8A); chk("R6 prescaler off", 32'(div5_en), 32'd0);
        send(8'h8B); chk("R6 prescaler on", 32'(div5_en), 32'd1);
        send(8'h8C); chk("R6 three-phase on", 32'(three_ph_en), 32'd1);
        send(8'h8D); chk("R6 three-phase off", 32'(three_ph_en), 32'd0);
        send(8'h96); chk("R6 adaptive on", 32'(adapt_en), 32'd1);
        send(8'h97); chk("R6 adaptive off", 32'(adapt_en), 32'd0);
    endtask

    task automatic t_flush();
        chk("R7 flush idle", 32'(rsp_flush), 32'd0);
        send(8'h87);
        chk("R7 flush pulse", 32'(rsp_flush), 32'd1);
        @(negedge clk); #1;
        chk("R7 flush one cycle", 32'(rsp_flush), 32'd0);
    endtask

    task automatic t_wait();
        pin_in[5] = 1'b0;
        send(8'h88);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk("R8 stall on 0x88", 32'(cmd_ready), 32'd0);
        end
        pin_in[5] = 1'b1;
        send(8'h84);
        chk("R8 resumes after pin high", 32'(loop_en), 32'd1);
        send(8'h89);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R8 stall on 0x89", 32'(cmd_ready), 32'd0);
        end
        pin_in[5] = 1'b0;
        send(8'h85);
        chk("R8 resumes after pin low", 32'(loop_en), 32'd0);
    endtask

    task automatic t_error();
        send(8'h9C);
        pop("R9 error tag", 8'hFA);
        pop("R9 error opcode", 8'h9C);
        send(8'h8E);
        pop("R9 error tag", 8'hFA);
        pop("R9 error opcode", 8'h8E);
    endtask

    task automatic t_shift();
        n_start = 0;
        n_fwd   = 0;
        sh_in_ready = 1'b0;
        send(8'h19);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = 8'h01;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R10 ready follows engine", 32'(cmd_ready), 32'd0);
        end
        @(negedge clk);
        sh_in_ready = 1'b1;
        #1;
        chk("R10 ready when engine ready", 32'(cmd_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        send(8'h00);
        send(8'hA5);
        @(negedge clk);
        sh_rsp_valid = 1'b1;
        sh_rsp_data  = 8'h5A;
        #1;
        chk("R10 engine reply taken", 32'(sh_rsp_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        sh_rsp_valid = 1'b0;
        sh_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sh_done = 1'b0;
        #1;
        chk("R10 idle after done", 32'(cmd_ready), 32'd1);
        chk("R10 one start strobe", 32'(n_start), 32'd1);
        chk("R10 opcode handed over", 32'(last_op), 32'h19);
        chk("R10 forwarded count", 32'(n_fwd), 32'd3);
        chk("R10 forwarded bytes", {8'd0, fwd[0], fwd[1], fwd[2]}, 32'h0001_00A5);
        pop("R10 engine reply in FIFO", 8'h5A);
    endtask

    task automatic t_fifo();
        pin_in = 16'h3CC3;
        for (int i = 0; i < 17; i++) begin
            send((i % 2 == 0) ? 8'h81 : 8'h83);
        end
        @(negedge clk); #1;
        chk("R11 parser stalls when full", 32'(cmd_ready), 32'd0);
        for (int i = 0; i < 17; i++) begin
            pop("R11 reply order", (i % 2 == 0) ? 8'hC3 : 8'h3C);
        end
        chk("R11 drained", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_disable();
        send(8'h80); send(8'hFF); send(8'hFF);
        send(8'h84); send(8'h8A);
        send(8'h81);
        pin_in[5] = 1'b1;
        send(8'h89);
        @(negedge clk);
        enable = 1'b0;
        #1;
        chk("R12 not ready while disabled", 32'(cmd_ready), 32'd0);
        @(negedge clk); #1;
        chk("R12 regs cleared", {pin_out, pin_dir}, 32'h0);
        chk("R12 flags reset", {29'd0, loop_en, div5_en, rsp_valid}, 32'b010);
        enable = 1'b1;
        @(negedge clk); #1;
        chk("R12 stall ended", 32'(cmd_ready), 32'd1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_pins();
        t_read();
        t_loop();
        t_div();
        t_modes();
        t_flush();
        t_wait();
        t_error();
        t_shift();
        t_fifo();
        t_disable();
        finish_run();
    end

endmodule